// File: doc/BRIEF.md
# Shift-and-Add Divide-by-Three Unit

This block gives an approximate unsigned quotient of an operand by three using only shifts and additions. It relies on the identity 1/3 = 1/4 + 1/16 + 1/64 + ... and evaluates a truncated form of that series one term per clock. A working register holds the running term and starts at the operand. In each step the term is shifted right by two bit positions and the new term is added into an accumulator. The loop stops when the term reaches zero.

A client pulses `start` with the operand on `x` while the unit is idle. `busy` stays high while the series runs. `done` pulses for one cycle when the accumulated sum is placed on `quotient`. Each term is truncated before it is added, so the result is the bit-exact series value and is not always floor(x/3). For example, operands 2 and 3 both give 0. The operand and the result have the same width `W`, and `W` must be greater than 2.

Top module: `tri_series_div`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `done` is 0 and `quotient` is 0.
- R2: A `start` sampled high while `busy` is low loads the operand `x` and clears the accumulator. `busy` is high in the following cycle.
- R3: In each busy cycle where the working term is nonzero, the term is shifted right by two bit positions (a logical shift, zero filled) and the shifted value is added into the accumulator.
- R4: In a busy cycle where the working term is zero, the run ends. In the next cycle `done` is high for exactly one cycle, `busy` is low, and `quotient` carries the accumulated sum.
- R5: The result equals the series sum of (x>>2) + (x>>4) + (x>>6) + ..., with each term truncated. For example, x=256 gives 85 (0x55), x=3 gives 0 and x=2 gives 0.
- R6: An operand of 0 ends on the first test. `done` comes one cycle after the start is accepted, with `quotient` = 0.
- R7: `done` rises k+1 clock edges after the accepting edge, where k is ceil(b/2) and b is the bit length of x (b=0 for x=0). This is never more than ceil(W/2)+1 edges.
- R8: A `start` that arrives while `busy` is high is ignored. The run in progress and its result are unaffected.
- R9: `quotient` holds the last completed result until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a run, accepted only when idle |
| x | input | W | Unsigned operand, sampled on the accepting edge |
| quotient | output | W | Last completed series result |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when `quotient` is updated |

## Verification
The assertions assume that `start` and `x` are driven to known values from reset onward. They also assume that `x` matters only on an edge where the unit is idle, so the properties follow the registered term rather than the live operand. The stimulus changes inputs only on the falling clock edge. It sweeps every operand of a 9-bit configuration. On some runs it drives a second `start` with a different operand while the unit is busy, which tests that the busy guard holds while inputs keep changing.

// File: rtl/tri_series_div_pkg.sv
// Package: tri_series_div_pkg
// Shared helpers for the divide-by-three series unit.
// Assumes: widths passed in are greater than 2.
package tri_series_div_pkg;

    // Upper bound on busy cycles for an operand of width w
    function automatic int max_busy_cycles(input int w);
        return (w + 1) / 2 + 1;
    endfunction

    // Width needed for a counter that must reach n
    function automatic int count_bits(input int n);
        return $clog2(n + 2);
    endfunction

endpackage

// File: rtl/tri_series_ctrl.sv
// Module: tri_series_ctrl
// Sequencing for one series run. It accepts start when idle, steps
// while the term is nonzero and finishes on a zero term.
// Assumes: term_zero comes from the registered working term.
module tri_series_ctrl
    import tri_series_div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic term_zero,
    output logic busy,
    output logic done,
    output logic load,
    output logic step,
    output logic finish
);
    localparam int MAXC = max_busy_cycles(W);
    localparam int CW   = count_bits(MAXC);

    logic [CW-1:0] busy_cnt;

    // Decode the per-cycle actions from the phase and the term
    always_comb begin
        load   = start && !busy;
        step   = busy && !term_zero;
        finish = busy && term_zero;
    end

    // Phase and completion pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (load)
                busy <= 1'b1;
            else if (finish)
                busy <= 1'b0;
        end
    end

    // Counts busy cycles so the latency bound can be checked
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            busy_cnt <= '0;
        else if (busy && busy_cnt != CW'(MAXC + 1))
            busy_cnt <= busy_cnt + 1'b1;
    end

    // R7
    latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < CW'(MAXC)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

// File: rtl/tri_series_term.sv
// Module: tri_series_term
// Working term register. It loads the operand and is divided by four
// on each step.
// Assumes: load and step are never high together.
module tri_series_term #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] x,
    output logic [W-1:0] term_next,
    output logic         term_zero
);
    logic [W-1:0] term;

    // Next term is a zero-filled shift right by two
    always_comb begin
        term_next = {2'b00, term[W-1:2]};
        term_zero = (term == '0);
    end

    // Holds the current series term
    always_ff @(posedge clk) begin
        if (!rst_n)
            term <= '0;
        else if (load)
            term <= x;
        else if (step)
            term <= term_next;
    end

    // R3
    term_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (term == ($past(term) >> 2)));

    // R3
    term_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (term < $past(term)));

endmodule

// File: rtl/tri_series_acc.sv
// Module: tri_series_acc
// Accumulates shifted terms and publishes the sum when a run finishes.
// Assumes: the series sum never exceeds the operand, so W bits suffice.
module tri_series_acc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         finish,
    input  logic [W-1:0] addend,
    output logic [W-1:0] quotient
);
    logic [W-1:0] sum;

    // Running sum of the series terms
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            sum <= '0;
        else if (step)
            sum <= sum + addend;
    end

    // Result register, updated only when a run completes
    always_ff @(posedge clk) begin
        if (!rst_n)
            quotient <= '0;
        else if (finish)
            quotient <= sum;
    end

    // R9
    quotient_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(quotient));

    // R3
    sum_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (sum >= $past(sum)));

endmodule

// File: rtl/tri_series_div.sv
// Module: tri_series_div
// Top level of the divide-by-three unit. It computes the sum of x/4 +
// x/16 + ... with truncated terms, one term per clock.
// Assumes: W > 2. A start while busy is dropped.
module tri_series_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] x,
    output logic [W-1:0] quotient,
    output logic         busy,
    output logic         done
);
    logic         load;
    logic         step;
    logic         finish;
    logic         term_zero;
    logic [W-1:0] term_next;

    // Parameter guard checked at elaboration
    initial begin
        width_param_chk: assert (W > 2);
    end

    tri_series_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .term_zero(term_zero),
        .busy(busy), .done(done), .load(load), .step(step), .finish(finish)
    );

    tri_series_term #(.W(W)) u_term (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .x(x),
        .term_next(term_next), .term_zero(term_zero)
    );

    tri_series_acc #(.W(W)) u_acc (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .finish(finish),
        .addend(term_next), .quotient(quotient)
    );

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);

endmodule

// File: tb/tri_series_div_test.sv
// Bench: sweeps every operand of a 9-bit unit and compares the result
// and the latency against an arithmetic model of the truncated series.
module tri_series_div_test;
    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] x = '0;
    logic [W-1:0] quotient;
    logic         busy;
    logic         done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    tri_series_div #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .x(x),
        .quotient(quotient), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One run; when inject is set a second start with another operand
    // is driven while the unit is busy.
    task automatic run(input int xv, input bit inject);
        int exp_q = 0;
        int p = xv;
        int k = 0;
        int lat = 0;
        while (p != 0) begin
            p = p >> 2;
            exp_q += p;
            k++;
        end
        @(negedge clk);
        start = 1'b1;
        x = W'(xv);
        @(negedge clk);
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        if (inject) begin
            start = 1'b1;
            x = ~W'(xv);
        end else begin
            start = 1'b0;
        end
        while (!done && lat < 40) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        check(lat == k + 1, inject ? "R8 latency with busy start" : "R7 latency",
              lat, k + 1);
        check(int'(quotient) == exp_q,
              (xv == 0) ? "R6 zero operand" : (inject ? "R8 result" : "R5 result"),
              int'(quotient), exp_q);
        check(busy == 1'b0, "R4 busy low at done", int'(busy), 0);
        @(negedge clk);
        check(done == 1'b0, "R4 done single cycle", int'(done), 0);
        @(negedge clk);
        check(int'(quotient) == exp_q, "R9 quotient held", int'(quotient), exp_q);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        check(done == 1'b0, "R1 done reset", int'(done), 0);
        check(quotient == '0, "R1 quotient reset", int'(quotient), 0);
        rst_n = 1'b1;
        // named corner cases: R5 and R6
        run(256, 1'b0);
        check(quotient == 9'd85, "R5 x=256 gives 85", int'(quotient), 85);
        run(3, 1'b0);
        check(quotient == 9'd0, "R5 x=3 gives 0", int'(quotient), 0);
        run(2, 1'b0);
        run(0, 1'b0);
        run(511, 1'b0);
        for (int v = 0; v < (1 << W); v++)
            run(v, (v % 5) == 2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure
    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule